// File: doc/BRIEF.md
# Multi-Function Self-Test Register

A four-bit register that serves several roles around a block of combinational logic during built-in self-test. A two-bit mode input picks one of four functions for each clock edge. It can capture the four parallel data inputs like an ordinary pipeline register, or shift serially as one segment of a scan chain. It can fold the parallel inputs into a running signature as a multiple-input signature compressor, or it can zero itself.

In scan mode, bits enter at the low end of the register and leave at the high end. The serial output is always the top stage, so several registers can be chained. In signature mode, the same first-stage multiplexer that takes the serial input during scan selects the top stage's output instead. Each stage then XORs its parallel input with the stage below it. The feedback follows the primitive polynomial 1 + x + x^4. With all-zero inputs the register therefore steps through all fifteen nonzero states. Any single-bit error in a compressed stream leaves a signature that differs from the fault-free one.

Top module: `obs_selftest_reg`

## Requirements
- R1: While `rst_n` is low, `q` is 4'b0000, and it clears as soon as `rst_n` falls, without waiting for a clock edge.
- R2: With `mode` = 2'b11 (load), `q` takes the value of `d` at the next rising edge of `clk`.
- R3: With `mode` = 2'b00 (scan), `q[0]` takes `scan_in` and each `q[k]` takes `q[k-1]` at the rising edge. A bit that is shifted in appears on `scan_out` after the fourth shift.
- R4: `scan_out` equals `q[3]` at all times.
- R5: With `mode` = 2'b10 (signature), the next state is computed from the current `q` and `d` as follows: `q0 <= d0 ^ q3`, `q1 <= d1 ^ q0 ^ q3`, `q2 <= d2 ^ q1`, `q3 <= d3 ^ q2`. This is the polynomial 1 + x + x^4 with feedback taken from `q3`.
- R6: With `mode` = 2'b01 (clear), `q` becomes 4'b0000 at the next edge whatever `d` and `scan_in` are. In each mode exactly one of the four functions acts.
- R7: In signature mode with `d` held at 0, starting from 4'b0001, `q` returns to 4'b0001 after exactly 15 edges and at no earlier edge.
- R8: Compressing an 8-word stream from the cleared state gives the signature that the reference model computes. Flipping any single bit of any word of that stream gives a different signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Function select: 11 load, 00 scan, 10 signature, 01 clear |
| d | input | 4 | Parallel data inputs |
| scan_in | input | 1 | Serial scan input to stage 0 |
| q | output | 4 | Parallel register outputs |
| scan_out | output | 1 | Serial scan output (top stage) |

## Verification
The assertions check the following on every cycle:
- the reset state;
- the load, shift, clear and signature transitions, each against the previous cycle's inputs;
- the first-stage multiplexer's choice between the serial input and the feedback;
- that the mode decoder raises exactly one function.

Some properties span many cycles and only the bench scenarios can show them:
- the fifteen-state cycle with zero input;
- the arrival of scanned bits at the serial output four shifts later;
- the detection of every single-bit error across an eight-word compression.

// File: rtl/obs_pkg.sv
`timescale 1ns/1ps
package obs_pkg;

  // Register width is fixed at four stages.
  localparam int unsigned OBS_W = 4;

  // Feedback mask for 1 + x + x^4: bit 0 is fed through the first-stage
  // multiplexer, the remaining set bits are XOR taps inside the chain.
  localparam logic [OBS_W-1:0] OBS_TAPS = 4'b0011;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_LOAD  = 2'b11
  } obs_mode_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic sig;
    logic clear;
  } obs_sel_t;

  // Move every stage one place upward, inserting a new bit at stage 0.
  function automatic logic [OBS_W-1:0] obs_chain_shift(
    input logic [OBS_W-1:0] cur,
    input logic             first
  );
    return {cur[OBS_W-2:0], first};
  endfunction

  // Fold parallel inputs into an already shifted chain, adding the
  // feedback bit at the inner tap positions.
  function automatic logic [OBS_W-1:0] obs_fold(
    input logic [OBS_W-1:0] shifted,
    input logic [OBS_W-1:0] din,
    input logic             fb,
    input logic [OBS_W-1:0] inner_taps
  );
    return shifted ^ din ^ (inner_taps & {OBS_W{fb}});
  endfunction

endpackage

// File: rtl/obs_mode_dec.sv
`timescale 1ns/1ps
module obs_mode_dec
  import obs_pkg::*;
(
  input  logic [1:0] mode_i,
  output obs_sel_t   sel_o
);

  always_comb begin
    sel_o = '0;
    unique case (obs_mode_e'(mode_i))
      MODE_LOAD:  sel_o.load  = 1'b1;
      MODE_SHIFT: sel_o.shift = 1'b1;
      MODE_SIG:   sel_o.sig   = 1'b1;
      MODE_CLEAR: sel_o.clear = 1'b1;
      default:    sel_o       = '0;
    endcase
  end

endmodule

// File: rtl/obs_next_net.sv
`timescale 1ns/1ps
module obs_next_net
  import obs_pkg::*;
#(
  parameter logic [OBS_W-1:0] TAPS = OBS_TAPS
) (
  input  logic [OBS_W-1:0] q_i,
  input  logic [OBS_W-1:0] d_i,
  input  logic             scan_in_i,
  input  obs_sel_t         sel_i,
  output logic             chain_in_o,
  output logic [OBS_W-1:0] nxt_o
);

  localparam int unsigned W = OBS_W;
  // Bit 0 of the mask is served by the first-stage multiplexer.
  localparam logic [W-1:0] INNER = {TAPS[W-1:1], 1'b0};

  logic             fb_bit;
  logic [W-1:0]     shifted;
  logic [W-1:0]     sig_next;

  assign fb_bit     = q_i[W-1];
  // First-stage multiplexer: scan input or top-stage feedback.
  assign chain_in_o = sel_i.sig ? fb_bit : scan_in_i;
  assign shifted    = obs_chain_shift(q_i, chain_in_o);
  assign sig_next   = obs_fold(shifted, d_i, fb_bit, INNER);

  always_comb begin
    nxt_o = '0;
    unique case (1'b1)
      sel_i.load:  nxt_o = d_i;
      sel_i.shift: nxt_o = shifted;
      sel_i.sig:   nxt_o = sig_next;
      sel_i.clear: nxt_o = '0;
      default:     nxt_o = '0;
    endcase
  end

endmodule

// File: rtl/obs_state_reg.sv
`timescale 1ns/1ps
module obs_state_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= nxt_i[i];
    end
  end

endmodule

// File: rtl/obs_selftest_reg.sv
`timescale 1ns/1ps
module obs_selftest_reg
  import obs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [OBS_W-1:0] d,
  input  logic             scan_in,
  output logic [OBS_W-1:0] q,
  output logic             scan_out
);

  obs_sel_t         sel;
  logic             sel_load;
  logic             sel_shift;
  logic             sel_sig;
  logic             sel_clear;
  logic             chain_in;
  logic [OBS_W-1:0] nxt;

  obs_mode_dec u_dec (
    .mode_i (mode),
    .sel_o  (sel)
  );

  assign sel_load  = sel.load;
  assign sel_shift = sel.shift;
  assign sel_sig   = sel.sig;
  assign sel_clear = sel.clear;

  obs_next_net #(.TAPS(OBS_TAPS)) u_net (
    .q_i        (q),
    .d_i        (d),
    .scan_in_i  (scan_in),
    .sel_i      (sel),
    .chain_in_o (chain_in),
    .nxt_o      (nxt)
  );

  obs_state_reg #(.W(OBS_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt_i (nxt),
    .q_o   (q)
  );

  assign scan_out = q[OBS_W-1];

endmodule

// File: rtl/obs_selftest_reg_chk.sv
`timescale 1ns/1ps
module obs_selftest_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [3:0] d,
  input logic       scan_in,
  input logic [3:0] q,
  input logic       sel_load,
  input logic       sel_shift,
  input logic       sel_sig,
  input logic       sel_clear,
  input logic       chain_in
);

  // R1: held reset keeps the register at zero
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> q == 4'b0000);

  // R2: load captures the parallel inputs
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> q == $past(d));

  // R3: scan moves bits upward and enters scan_in at stage 0
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> q == {$past(q[2:0]), $past(scan_in)});

  // R3: first-stage multiplexer takes the serial input in scan mode
  a_r3_chain_scan: assert property (@(posedge clk) disable iff (!rst_n)
    sel_shift |-> chain_in == scan_in);

  // R5: first-stage multiplexer takes the top stage in signature mode
  a_r5_chain_fb: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sig |-> chain_in == q[3]);

  // R5: signature step, restated as a difference against the inputs
  a_r5_misr: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> (q ^ $past(d)) ==
      ({$past(q[2:0]), 1'b0} ^ {2'b00, $past(q[3]), $past(q[3])}));

  // R6: clear zeroes the register
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> q == 4'b0000);

  // R6: one function active per mode
  a_r6_one_function: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_load, sel_shift, sel_sig, sel_clear}) == 1);

endmodule

bind obs_selftest_reg obs_selftest_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .d         (d),
  .scan_in   (scan_in),
  .q         (q),
  .sel_load  (sel_load),
  .sel_shift (sel_shift),
  .sel_sig   (sel_sig),
  .sel_clear (sel_clear),
  .chain_in  (chain_in)
);

// File: tb/obs_selftest_reg_bench.sv
`timescale 1ns/1ps
module obs_selftest_reg_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst_n;
  logic [1:0] mode;
  logic [3:0] d;
  logic       scan_in;
  wire  [3:0] q;
  wire        scan_out;

  obs_selftest_reg u_obs_selftest_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .d        (d),
    .scan_in  (scan_in),
    .q        (q),
    .scan_out (scan_out)
  );

  int checks   = 0;
  int failures = 0;
  int exp_q    = 0;
  bit done     = 0;
  int sq[$];
  int words[8] = '{9, 4, 14, 1, 7, 12, 3, 10};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Behavioural reference: integer arithmetic on the state value.
  function automatic int model_next(input int m, input int cur, input int dv, input int si);
    case (m)
      3: return dv;
      0: return ((cur * 2) % 16) + si;
      2: return ((cur * 2) % 16) ^ dv ^ ((cur >= 8) ? 3 : 0);
      default: return 0;
    endcase
  endfunction

  // Called at a falling edge; compares just after the next rising edge.
  task automatic step(input int m, input int dv, input int si, input string req);
    mode    = m[1:0];
    d       = dv[3:0];
    scan_in = si[0];
    exp_q   = model_next(m, exp_q, dv, si);
    @(posedge clk);
    #1;
    check(q == exp_q[3:0], req, "q", int'(q), exp_q);
    check(scan_out == exp_q[3], "R4", "scan_out", int'(scan_out), exp_q / 8);
    @(negedge clk);
  endtask

  task automatic compress(input int fw, input int fb, output int sig);
    step(1, 15, 1, "R6");
    for (int i = 0; i < 8; i++) begin
      int w = words[i];
      if (i == fw) w = w ^ (1 << fb);
      step(2, w, 0, "R8");
    end
    sig = int'(q);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int golden;
    int sig;
    rst_n = 1'b0; mode = 2'b11; d = 4'hF; scan_in = 1'b1;
    #3;
    check(q == 4'b0000, "R1", "q in reset", int'(q), 0);
    check(scan_out == 1'b0, "R1", "scan_out in reset", int'(scan_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q = 0;

    // R2 load with several patterns
    step(3, 10, 0, "R2");
    step(3, 5, 1, "R2");
    step(3, 15, 0, "R2");
    // R6 clear ignores d and scan_in
    step(1, 15, 1, "R6");
    step(3, 6, 0, "R2");
    step(1, 9, 0, "R6");

    // R3 scan ordering toward the top stage
    sq.delete();
    for (int k = 0; k < 10; k++) begin
      int b = (k == 0 || k == 2 || k == 3 || k == 6 || k == 9) ? 1 : 0;
      step(0, 5, b, "R3");
      sq.push_back(b);
      if (sq.size() > 4) void'(sq.pop_front());
      if (sq.size() == 4)
        check(scan_out == sq[0][0], "R3", "scan_out order", int'(scan_out), sq[0]);
    end

    // R5 signature steps from several states
    step(3, 9, 0, "R2");
    step(2, 6, 0, "R5");
    step(2, 0, 1, "R5");
    step(2, 15, 0, "R5");
    step(3, 8, 0, "R2");
    step(2, 0, 0, "R5");
    step(2, 11, 1, "R5");

    // R7 fifteen-state cycle with zero input
    step(3, 1, 0, "R2");
    for (int k = 1; k <= 15; k++) begin
      step(2, 0, 0, "R7");
      if (k < 15) check(q != 4'b0001, "R7", "early return", int'(q), -1);
      else        check(q == 4'b0001, "R7", "period end", int'(q), 1);
    end

    // R8 golden signature and single-bit error detection
    compress(-1, 0, golden);
    check(golden == exp_q, "R8", "golden signature", golden, exp_q);
    for (int w = 0; w < 8; w++) begin
      for (int b = 0; b < 4; b++) begin
        compress(w, b, sig);
        check(sig != golden, "R8", "flipped signature", sig, golden);
      end
    end

    // R1 asynchronous reset between clock edges
    step(3, 15, 0, "R2");
    #1 rst_n = 1'b0;
    #0.5;
    check(q == 4'b0000, "R1", "q after async reset", int'(q), 0);
    check(scan_out == 1'b0, "R1", "scan_out after async reset", int'(scan_out), 0);
    exp_q = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 1, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule